// File: doc/BRIEF.md
# Recursive Indexed-Indirect Effective Address Unit

This unit computes the effective address of a 36-bit instruction word. It adds an optional index register to the 18-bit address field. When the word's indirect flag is set, it reads the word at that address and decodes it again for a new index, address and indirect flag. This repeats until a word arrives with the flag clear. A chain of indirect words can point back on itself, so a hop guard counts the memory reads. The guard ends the walk with an error once a parameter-set limit is reached.

The caller presents a word with a one-cycle start strobe and then waits for the unit to leave its busy state. The unit reads index values from an external 16-entry register file through a combinational select/data pair. It fetches indirect words over a request/ready handshake, and the read data is taken in the cycle that ready is high. The final address is returned as a number only. No operand is read from it.

Top module: `eaw_walker`

## Requirements
- R1: While reset is low at a clock edge, the following edge shows `busy_o`, `done_o`, `err_o` and `mem_valid_o` all low.
- R2: Bits are counted 0 to 35 from the MSB. The address field is bits 18..35 (vector bits 17:0), the index field is bits 14..17 (vector bits 21:18) and the indirect flag is bit 13 (vector bit 22). For a word whose indirect flag is 0 and whose index field is 0, `ea_o` equals the address field and `done_o` is high one clock after the start edge, with no memory request made.
- R3: For a nonzero index field, `ea_o` is the address field plus bits 17:0 of the selected register, taken modulo 2^18.
- R4: An index field of 0 selects no register, and the contents of register 0 have no effect on the result.
- R5: With the indirect flag set, the unit raises `mem_valid_o` with `mem_addr_o` equal to the current effective address. It holds both unchanged until `mem_ready_i` is high.
- R6: Each fetched word is decoded again. Its own index and indirect fields apply, so a chain of any length below the limit resolves to the address computed from its last word.
- R7: When `MAX_HOPS` reads have been made and the latest word still has the indirect flag set, the unit raises `err_o`, leaves `done_o` low and makes no further read.
- R8: A start strobe is ignored while `busy_o` is high.
- R9: `busy_o` is high from the edge that accepts a start until the edge that raises `done_o` or `err_o`. No memory request is made while `busy_o` is low, and `ea_o`, `done_o` and `err_o` hold until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start strobe, one cycle |
| instr_i | input | 36 | Instruction word to resolve |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | Effective address ready |
| err_o | output | 1 | Hop limit reached |
| ea_o | output | 18 | Resolved effective address |
| rf_sel_o | output | 4 | Register file read select |
| rf_data_i | input | 36 | Register file read data |
| mem_valid_o | output | 1 | Indirect word read request |
| mem_addr_o | output | 18 | Indirect word address |
| mem_ready_i | input | 1 | Memory accepts request; data valid |
| mem_rdata_i | input | 36 | Fetched indirect word |

## Verification
On every cycle the assertions check the following. A stalled request keeps its address. No request appears while idle. Done and error never rise together. The hop count never passes its limit. Reset clears the flags. The bench scenarios cover what needs a reference value: address sums with and without an index, wraparound at 2^18, chains with memory stalls, an endless self-pointing chain, and a start pulse dropped in the middle of a walk.

// File: rtl/eaw_pkg.sv
// Package: shared widths, field positions and FSM state type for the
// effective address walker. Assumes MSB-first bit numbering of the word.
package eaw_pkg;
    localparam int WORD_W  = 36;
    localparam int ADDR_W  = 18;
    localparam int IDX_W   = 4;
    localparam int NREGS   = 1 << IDX_W;
    // MSB-numbered bit 13 maps to vector bit WORD_W-1-13
    localparam int IND_POS = WORD_W - 1 - 13;
    localparam int IDX_LSB = ADDR_W;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CALC  = 2'd1,
        ST_FETCH = 2'd2
    } walk_st_e;

    typedef struct packed {
        logic              ind;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] addr;
    } ref_fields_t;
endpackage

// File: rtl/eaw_field_split.sv
// Module: splits an instruction or indirect word into the fields that the
// address walk uses. Opcode and accumulator bits are not needed here.
module eaw_field_split
    import eaw_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output ref_fields_t       fields_o
);
    logic unused_upper;

    // Pick indirect flag, index select and address field out of the word
    always_comb begin
        fields_o.ind  = word_i[IND_POS];
        fields_o.idx  = word_i[IDX_LSB +: IDX_W];
        fields_o.addr = word_i[ADDR_W-1:0];
    end

    assign unused_upper = ^word_i[WORD_W-1:IND_POS+1];
endmodule

// File: rtl/eaw_index_add.sv
// Module: forms address field plus index register low bits, modulo 2^ADDR_W.
// Assumes index select 0 means "no index", whatever register 0 holds.
module eaw_index_add
    import eaw_pkg::*;
(
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WORD_W-1:0] reg_i,
    output logic [ADDR_W-1:0] sum_o
);
    logic [ADDR_W-1:0] offset;
    logic              unused_reg_hi;

    // Gate the register value off when no index is selected
    always_comb begin
        offset = (idx_i != '0) ? reg_i[ADDR_W-1:0] : '0;
        sum_o  = addr_i + offset;
    end

    assign unused_reg_hi = ^reg_i[WORD_W-1:ADDR_W];
endmodule

// File: rtl/eaw_hop_guard.sv
// Module: counts indirect reads in one walk and flags when the limit is met.
// Assumes clear and bump are never high together.
module eaw_hop_guard #(
    parameter int MAX_HOPS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic bump_i,
    output logic at_limit_o
);
    localparam int CNT_W = $clog2(MAX_HOPS + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_HOPS);

    logic [CNT_W-1:0] hops_q;

    // Count reads issued since the last accepted start
    always_ff @(posedge clk) begin
        if (!rst_n)       hops_q <= '0;
        else if (clear_i) hops_q <= '0;
        else if (bump_i)  hops_q <= hops_q + 1'b1;
    end

    assign at_limit_o = (hops_q == LIMIT);

    assert_hops_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hops_q <= LIMIT);
    assert_no_bump_at_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        at_limit_o |-> !bump_i);
endmodule

// File: rtl/eaw_walker.sv
// Module: top of the recursive indexed-indirect effective address unit.
// Takes one word per start, walks indirect chains through a request/ready
// memory port (data valid with ready), bounds the walk by MAX_HOPS reads.
// Assumes the register file read is combinational on rf_sel_o.
module eaw_walker
    import eaw_pkg::*;
#(
    parameter int MAX_HOPS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [35:0]       instr_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [17:0]       ea_o,
    output logic [3:0]        rf_sel_o,
    input  logic [35:0]       rf_data_i,
    output logic              mem_valid_o,
    output logic [17:0]       mem_addr_o,
    input  logic              mem_ready_i,
    input  logic [35:0]       mem_rdata_i
);
    walk_st_e          st_q;
    logic [WORD_W-1:0] word_q;
    logic [ADDR_W-1:0] ea_q;
    logic [ADDR_W-1:0] req_addr_q;
    logic              done_q;
    logic              err_q;
    ref_fields_t       cur;
    logic [ADDR_W-1:0] sum;
    logic              at_limit;
    logic              accept;
    logic              bump;

    eaw_field_split u_split (
        .word_i   (word_q),
        .fields_o (cur)
    );

    eaw_index_add u_add (
        .idx_i  (cur.idx),
        .addr_i (cur.addr),
        .reg_i  (rf_data_i),
        .sum_o  (sum)
    );

    eaw_hop_guard #(.MAX_HOPS(MAX_HOPS)) u_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (accept),
        .bump_i     (bump),
        .at_limit_o (at_limit)
    );

    // Handshake qualifiers between the FSM and the hop guard
    always_comb begin
        accept = (st_q == ST_IDLE) && start_i;
        bump   = (st_q == ST_CALC) && cur.ind && !at_limit;
    end

    // Walk state machine: decode, add index, fetch while indirect
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_IDLE;
            word_q     <= '0;
            ea_q       <= '0;
            req_addr_q <= '0;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (start_i) begin
                        word_q <= instr_i;
                        done_q <= 1'b0;
                        err_q  <= 1'b0;
                        st_q   <= ST_CALC;
                    end
                end
                ST_CALC: begin
                    if (!cur.ind) begin
                        ea_q   <= sum;
                        done_q <= 1'b1;
                        st_q   <= ST_IDLE;
                    end else if (at_limit) begin
                        err_q  <= 1'b1;
                        st_q   <= ST_IDLE;
                    end else begin
                        req_addr_q <= sum;
                        st_q       <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (mem_ready_i) begin
                        word_q <= mem_rdata_i;
                        st_q   <= ST_CALC;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Output drive
    always_comb begin
        busy_o      = (st_q != ST_IDLE);
        done_o      = done_q;
        err_o       = err_q;
        ea_o        = ea_q;
        rf_sel_o    = cur.idx;
        mem_valid_o = (st_q == ST_FETCH);
        mem_addr_o  = req_addr_q;
    end

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (!busy_o && !done_o && !err_o && !mem_valid_o));
    assert_req_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid_o && !mem_ready_i) |=> (mem_valid_o && $stable(mem_addr_o)));
    assert_done_err_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o));
    assert_no_req_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !mem_valid_o);
    assert_flags_from_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done_o) || $rose(err_o)) |-> $past(busy_o));
    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!busy_o) && !busy_o) |-> ($stable(ea_o) && $stable(done_o) && $stable(err_o)));
endmodule

// File: tb/eaw_walker_tb.sv
// Bench: directed scenarios for the effective address walker, one task each.
module eaw_walker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [35:0] instr_i = '0;
    logic        busy_o, done_o, err_o, mem_valid_o, mem_ready_i;
    logic [17:0] ea_o, mem_addr_o;
    logic [3:0]  rf_sel_o;
    logic [35:0] rf_data_i, mem_rdata_i;

    logic [35:0] regs [16];
    logic [35:0] mem  [64];
    int          stall = 0;
    int          wait_cnt = 0;
    int          fetch_total = 0;
    int          checks = 0;
    int          fails = 0;

    always #2.5 clk = ~clk;

    eaw_walker dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .instr_i(instr_i),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .ea_o(ea_o),
        .rf_sel_o(rf_sel_o), .rf_data_i(rf_data_i),
        .mem_valid_o(mem_valid_o), .mem_addr_o(mem_addr_o),
        .mem_ready_i(mem_ready_i), .mem_rdata_i(mem_rdata_i)
    );

    assign rf_data_i   = regs[rf_sel_o];
    assign mem_ready_i = mem_valid_o && (wait_cnt >= stall);
    assign mem_rdata_i = mem[mem_addr_o[5:0]];

    // Memory stall model and read counter
    always @(posedge clk) begin
        if (mem_valid_o && mem_ready_i) begin
            wait_cnt    <= 0;
            fetch_total <= fetch_total + 1;
        end else if (mem_valid_o) begin
            wait_cnt <= wait_cnt + 1;
        end
    end

    function automatic logic [35:0] mk(input logic ind, input logic [3:0] idx,
                                       input logic [17:0] addr);
        return {9'd0, 4'd0, ind, idx, addr};
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Launch one walk, wait for it to end; returns cycles and reads used
    task automatic walk(input logic [35:0] w, output int cycles, output int reads);
        int f0;
        f0 = fetch_total;
        @(negedge clk);
        instr_i = w;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cycles = 0;
        while (busy_o && cycles < 2000) begin
            @(negedge clk);
            cycles++;
        end
        if (busy_o) begin
            fails++;
            $display("FAIL watchdog: walk did not finish");
        end
        reads = fetch_total - f0;
    endtask

    task automatic t_reset;
        check("R1", "busy", int'(busy_o), 0);
        check("R1", "done", int'(done_o), 0);
        check("R1", "err", int'(err_o), 0);
        check("R1", "mem_valid", int'(mem_valid_o), 0);
    endtask

    task automatic t_direct;
        int c, r;
        walk(mk(1'b0, 4'd0, 18'h12345), c, r);
        check("R2", "ea", int'(ea_o), 'h12345);
        check("R2", "done", int'(done_o), 1);
        check("R2", "latency", c, 1);
        check("R2", "reads", r, 0);
    endtask

    task automatic t_indexed;
        int c, r;
        regs[5] = 36'hF_0000_0010;
        walk(mk(1'b0, 4'd5, 18'h00100), c, r);
        check("R3", "ea idx", int'(ea_o), 'h110);
        regs[3] = 36'h0_0003_FFFF;
        walk(mk(1'b0, 4'd3, 18'h00002), c, r);
        check("R3", "ea wrap", int'(ea_o), 'h1);
    endtask

    task automatic t_idx_zero;
        int c, r;
        regs[0] = 36'h0_0000_0777;
        walk(mk(1'b0, 4'd0, 18'h00050), c, r);
        check("R4", "ea reg0 ignored", int'(ea_o), 'h50);
    endtask

    task automatic t_single_ind;
        int c, r;
        stall = 0;
        mem[10] = mk(1'b0, 4'd0, 18'h02222);
        walk(mk(1'b1, 4'd0, 18'd10), c, r);
        check("R5", "ea", int'(ea_o), 'h2222);
        check("R5", "reads", r, 1);
    endtask

    task automatic t_chain;
        int c, r;
        stall = 2;
        regs[2] = 36'd30;
        regs[4] = 36'd5;
        mem[20] = mk(1'b1, 4'd2, 18'd3);
        mem[33] = mk(1'b0, 4'd4, 18'h00100);
        walk(mk(1'b1, 4'd0, 18'd20), c, r);
        check("R6", "ea", int'(ea_o), 'h105);
        check("R6", "reads", r, 2);
        check("R6", "done", int'(done_o), 1);
        stall = 0;
    endtask

    task automatic t_loop;
        int c, r;
        mem[40] = mk(1'b1, 4'd0, 18'd40);
        walk(mk(1'b1, 4'd0, 18'd40), c, r);
        check("R7", "err", int'(err_o), 1);
        check("R7", "done", int'(done_o), 0);
        check("R7", "reads", r, 64);
        @(negedge clk);
        check("R7", "no further read", int'(mem_valid_o), 0);
    endtask

    task automatic t_start_busy;
        int c;
        int f0;
        stall = 3;
        f0 = fetch_total;
        @(negedge clk);
        instr_i = mk(1'b1, 4'd0, 18'd10);
        start_i = 1'b1;
        @(negedge clk);
        instr_i = mk(1'b0, 4'd0, 18'h00777);
        @(negedge clk);
        start_i = 1'b0;
        check("R8", "busy mid-walk", int'(busy_o), 1);
        c = 0;
        while (busy_o && c < 2000) begin
            @(negedge clk);
            c++;
        end
        check("R8", "ea kept", int'(ea_o), 'h2222);
        check("R8", "reads", fetch_total - f0, 1);
        @(negedge clk);
        check("R9", "stays idle", int'(busy_o), 0);
        check("R9", "ea held", int'(ea_o), 'h2222);
        stall = 0;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) regs[i] = '0;
        for (int i = 0; i < 64; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_direct();
        t_indexed();
        t_idx_zero();
        t_single_ind();
        t_chain();
        t_loop();
        t_start_busy();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run timed out");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule